// File: doc/BRIEF.md
# Playback Byte-Count Interrupt Generator

This block follows how many playback bytes the DMA path has consumed, and compares that total with a programmed 16-bit sample count. The sample count is converted to bytes by a shift that depends on the sample format. When a burst lands exactly on the byte total, the block emits a one-cycle pulse. The surrounding logic uses that pulse to set both the status interrupt bit and the playback interrupt flag. The byte counter then starts again from zero, so the next block of samples is counted without software having to re-arm anything.

The block also owns the DMA request hold. A playback enable starts the request when the block is idle. Dropping the enable releases it, and so does a format error reported by the format decoder. A request for programmed-I/O mode keeps playback from starting. The block presents the bytes still outstanding before completion as a burst limit, so the DMA engine never overshoots the terminal count. With interrupts disabled, the limit reads as all ones and bursts go uncounted.

Top module: `pcm_count_irq`

## Requirements
- R1: After reset, `dreq_hold` and `irq_set` are 0 and the transferred byte count is 0, so with `irq_en`=1 the `burst_limit` equals the full terminal count.
- R2: The terminal count is {`cnt_hi`,`cnt_lo`} shifted left. The shift depends on `fmt` and `stereo`. For `fmt`=2'b00 (8-bit linear), 2'b01 (companded) and 2'b11 (reserved), the shift is 0 for mono and 1 for stereo. For `fmt`=2'b10 (16-bit), the shift is 1 for mono and 2 for stereo.
- R3: While `irq_en`=0, `burst_limit` is all ones and accepted bursts leave the transferred count unchanged.
- R4: While `irq_en`=1, `burst_limit` equals the terminal count minus the transferred count, saturating at 0.
- R5: A burst whose length equals the remaining count gives `irq_set`=1 for exactly one cycle, in the cycle after the burst. The transferred count returns to 0 at the same edge.
- R6: A counted burst shorter than the remaining count adds its length to the transferred count, visible in `burst_limit` one cycle later.
- R7: `play_en`=1 while idle, with `pio_mode`=0 and `fmt_err`=0, sets `dreq_hold` at the next edge and clears the transferred count.
- R8: `play_en`=0 clears `dreq_hold` at the next edge.
- R9: While `pio_mode`=1, playback does not start and `dreq_hold` stays 0.
- R10: `fmt_err`=1 clears `dreq_hold` at the next edge.
- R11: A burst of length 0 leaves the transferred count unchanged and raises no interrupt.
- R12: Bursts presented while `dreq_hold`=0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_hi | input | 8 | Upper byte of the sample count |
| cnt_lo | input | 8 | Lower byte of the sample count |
| fmt | input | 2 | Sample format code (see R2) |
| stereo | input | 1 | 1 = two channels |
| irq_en | input | 1 | Enables counting and burst limiting |
| play_en | input | 1 | Playback enable |
| pio_mode | input | 1 | Programmed-I/O request; blocks start |
| fmt_err | input | 1 | Format decoder reports an unusable format |
| xfer_valid | input | 1 | A burst of `xfer_len` bytes completed this cycle |
| xfer_len | input | LEN_W | Bytes in the burst |
| dreq_hold | output | 1 | DMA request held |
| irq_set | output | 1 | One-cycle pulse to set the status and playback interrupt bits |
| burst_limit | output | 2*BYTE_W+2 | Bytes left before completion, or all ones when unlimited |

## Verification
The transferred byte count is the only counting state, and `burst_limit` exposes it combinationally every cycle. A wrong add, a missed clear or a miscounted zero-length burst therefore shows at the port in the cycle right after the offending edge. A wrong run state shows as a `dreq_hold` level one edge after the controlling input changes. A wrong completion compare shows up as either a missing `irq_set` pulse or a spurious one in the cycle after the burst.

// File: rtl/pcm_count_irq.sv
module pcm_count_irq #(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 18
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BYTE_W-1:0]     cnt_hi,
  input  logic [BYTE_W-1:0]     cnt_lo,
  input  logic [1:0]            fmt,
  input  logic                  stereo,
  input  logic                  irq_en,
  input  logic                  play_en,
  input  logic                  pio_mode,
  input  logic                  fmt_err,
  input  logic                  xfer_valid,
  input  logic [LEN_W-1:0]      xfer_len,
  output logic                  dreq_hold,
  output logic                  irq_set,
  output logic [2*BYTE_W+1:0]   burst_limit
);
  localparam int SAMP_W = 2 * BYTE_W;
  localparam int CNT_W  = SAMP_W + 2;

  logic [1:0]       shift;
  logic [CNT_W-1:0] terminal, remaining, xferred, len_ext;
  logic             running, accept, hit, start;

  always_comb begin
    case (fmt)
      2'b10:   shift = stereo ? 2'd2 : 2'd1;
      default: shift = {1'b0, stereo};
    endcase
  end

  assign terminal  = CNT_W'({cnt_hi, cnt_lo}) << shift;
  assign remaining = (xferred >= terminal) ? '0 : terminal - xferred;
  assign len_ext   = CNT_W'(xfer_len);

  assign accept = xfer_valid && running && irq_en && (xfer_len != '0);
  assign hit    = accept && (len_ext == remaining);
  assign start  = play_en && !pio_mode && !fmt_err && !running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      xferred <= '0;
      irq_set <= 1'b0;
    end else begin
      irq_set <= hit;
      if (!play_en || fmt_err)
        running <= 1'b0;
      else if (start)
        running <= 1'b1;
      if (start || hit)
        xferred <= '0;
      else if (accept)
        xferred <= xferred + len_ext;
    end
  end

  assign dreq_hold   = running;
  assign burst_limit = irq_en ? remaining : '1;
endmodule

// File: rtl/pcm_count_irq_chk.sv
module pcm_count_irq_chk #(
  parameter int LEN_W = 18,
  parameter int CNT_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             play_en,
  input logic             pio_mode,
  input logic             fmt_err,
  input logic             irq_en,
  input logic             xfer_valid,
  input logic [LEN_W-1:0] xfer_len,
  input logic             dreq_hold,
  input logic             irq_set,
  input logic [CNT_W-1:0] xferred
);
  // R8
  release_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !play_en |=> !dreq_hold);

  // R10
  release_on_fmt_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |=> !dreq_hold);

  // R9
  start_needs_no_pio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dreq_hold) |-> $past(play_en && !pio_mode && !fmt_err));

  // R5
  irq_from_counted_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |-> $past(xfer_valid && dreq_hold && irq_en && (xfer_len != '0)));

  // R5
  irq_clears_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |-> (xferred == '0));

  // R11
  zero_len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_len == '0 && dreq_hold) |=> ($stable(xferred) && !irq_set));

  // R12
  idle_burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !dreq_hold && !play_en) |=> ($stable(xferred) && !irq_set));
endmodule

bind pcm_count_irq pcm_count_irq_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .play_en(play_en), .pio_mode(pio_mode),
  .fmt_err(fmt_err), .irq_en(irq_en), .xfer_valid(xfer_valid),
  .xfer_len(xfer_len), .dreq_hold(dreq_hold), .irq_set(irq_set),
  .xferred(xferred)
);

// File: tb/pcm_count_irq_tb.sv
module pcm_count_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cnt_hi = '0, cnt_lo = '0;
  logic [1:0]  fmt = '0;
  logic        stereo = 1'b0, irq_en = 1'b0, play_en = 1'b0;
  logic        pio_mode = 1'b0, fmt_err = 1'b0, xfer_valid = 1'b0;
  logic [17:0] xfer_len = '0;
  logic        dreq_hold, irq_set;
  logic [17:0] burst_limit;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pcm_count_irq u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .fmt(fmt),
    .stereo(stereo), .irq_en(irq_en), .play_en(play_en), .pio_mode(pio_mode),
    .fmt_err(fmt_err), .xfer_valid(xfer_valid), .xfer_len(xfer_len),
    .dreq_hold(dreq_hold), .irq_set(irq_set), .burst_limit(burst_limit)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic burst(int n);
    xfer_valid = 1'b1;
    xfer_len   = 18'(n);
    step();
    xfer_valid = 1'b0;
    xfer_len   = '0;
  endtask

  task automatic t_reset();
    cnt_hi = 8'h00; cnt_lo = 8'h10; irq_en = 1'b1;
    step();
    chk("R1 dreq", dreq_hold, 0);
    chk("R1 irq", irq_set, 0);
    chk("R1 limit", burst_limit, 16);
  endtask

  task automatic t_shift();
    cnt_hi = 8'h01; cnt_lo = 8'h00;
    fmt = 2'b00; stereo = 1'b0; #1 chk("R2 8bit mono", burst_limit, 256);
    stereo = 1'b1;              #1 chk("R2 8bit stereo", burst_limit, 512);
    fmt = 2'b01; stereo = 1'b0; #1 chk("R2 companded mono", burst_limit, 256);
    fmt = 2'b10;                #1 chk("R2 16bit mono", burst_limit, 512);
    stereo = 1'b1;              #1 chk("R2 16bit stereo", burst_limit, 1024);
    cnt_hi = 8'hff; cnt_lo = 8'hff; #1 chk("R2 16bit stereo max", burst_limit, 32'h3fffc);
    fmt = 2'b11; stereo = 1'b0; cnt_hi = 8'h01; cnt_lo = 8'h00;
    #1 chk("R2 reserved mono", burst_limit, 256);
    fmt = 2'b00; cnt_hi = 8'h00; cnt_lo = 8'h10;
    step();
  endtask

  task automatic t_count();
    play_en = 1'b1;
    step();
    chk("R7 start", dreq_hold, 1);
    burst(5);
    chk("R6 partial", burst_limit, 11);
    chk("R6 no irq", irq_set, 0);
    burst(0);
    chk("R11 zero len", burst_limit, 11);
    chk("R11 no irq", irq_set, 0);
    burst(11);
    chk("R5 irq pulse", irq_set, 1);
    chk("R5 reload", burst_limit, 16);
    step();
    chk("R5 single pulse", irq_set, 0);
    stereo = 1'b1; #1 chk("R4 limit follows shift", burst_limit, 32);
    stereo = 1'b0;
  endtask

  task automatic t_disabled();
    irq_en = 1'b0; #1 chk("R3 unlimited", burst_limit, 32'h3ffff);
    burst(4);
    chk("R3 no irq", irq_set, 0);
    irq_en = 1'b1; #1 chk("R3 not counted", burst_limit, 16);
  endtask

  task automatic t_stop();
    burst(3);
    chk("R6 add", burst_limit, 13);
    play_en = 1'b0;
    step();
    chk("R8 release", dreq_hold, 0);
    burst(2);
    chk("R12 idle ignored", burst_limit, 13);
    play_en = 1'b1;
    step();
    chk("R7 restart", dreq_hold, 1);
    chk("R7 cleared", burst_limit, 16);
  endtask

  task automatic t_pio();
    play_en = 1'b0;
    step();
    pio_mode = 1'b1; play_en = 1'b1;
    step(); step();
    chk("R9 pio blocks", dreq_hold, 0);
    pio_mode = 1'b0;
    step();
    chk("R9 start after pio", dreq_hold, 1);
  endtask

  task automatic t_fmt_err();
    burst(7);
    fmt_err = 1'b1;
    step();
    chk("R10 release", dreq_hold, 0);
    fmt_err = 1'b0;
    step();
    chk("R10 restart", dreq_hold, 1);
    chk("R7 cleared after err", burst_limit, 16);
  endtask

  initial begin
    step(); step();
    rst_n = 1'b1;
    t_reset();
    t_shift();
    t_count();
    t_disabled();
    t_stop();
    t_pio();
    t_fmt_err();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule